// File: doc/BRIEF.md
# Frame Rate Calibration Controller

This block sets the panel refresh rate from a timed software window. Software issues a start pulse, waits a nominal 200 ms and issues a stop pulse. While the window is open the block counts enabled cycles of the internal oscillator, and it measures the window length by counting a 1 ms time-base tick. When the length falls inside the acceptance band, the oscillator count divided by 16 becomes the new frame divider, because one sixteenth of 200 ms is one 80 Hz frame period. A window that is too short, too long or never closed is thrown away and the previous divider is kept.

A free-running frame generator turns the divider into a one-cycle frame tick. It counts oscillator cycles and stops while the chip is powered down. After every window ends, a lockout of 500 ms blocks new starts. Each new calibration replaces the divider, so repeated calibrations refine the rate step by step.

Top module: `fcal_ctrl`

## Requirements
- R1: After reset the divider holds its default value (64), both status pulses are low and no lockout is active, so a first start is taken at once.
- R2: A start pulse while `pwr_down` is high opens no window. It pulses `cal_drop` for one cycle and leaves the divider unchanged.
- R3: When a window is closed by `stop_req` with a length of 58 to 690 ticks inclusive, `cal_ok` pulses for one cycle after the stop edge. In that same cycle the divider becomes floor(N/16), where N is the number of clock edges with `osc_en` high taken after the start edge up to and including the stop edge. A result of 0 is stored as 1. The window length is the number of `ms_tick` edges over that same span.
- R4: A window closed at fewer than 58 ticks pulses `cal_drop` and keeps the divider.
- R5: A window that reaches a 691st tick without a stop is aborted on that edge. It pulses `cal_drop` and keeps the divider. A stop at exactly 690 ticks is accepted.
- R6: After a window ends (by stop, timeout or power-down) a lockout runs for 500 ticks. A start during the lockout, including one on the edge of the 500th tick, pulses `cal_drop`. A start on the next cycle opens a window.
- R7: Each accepted calibration replaces the divider left by the previous one.
- R8: `frame_tick` pulses once every divider-many `osc_en` cycles and never follows a cycle with `pwr_down` high.
- R9: A start while a window is open is ignored without a status pulse and does not restart the count. A stop with no window open has no effect. Power-down during a window aborts it with `cal_drop`.
- R10: `cal_ok` and `cal_drop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle calibration start command |
| stop_req | input | 1 | One-cycle calibration stop command |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| osc_en | input | 1 | Oscillator cycle enable |
| pwr_down | input | 1 | Chip is in power-down |
| divider | output | DIV_W | Oscillator cycles per frame |
| frame_tick | output | 1 | One-cycle frame pulse |
| cal_ok | output | 1 | Calibration accepted pulse |
| cal_drop | output | 1 | Attempt or start ignored pulse |

## Verification
Windows are driven with three oscillator patterns: every cycle, a pseudo-random half, and one cycle in three. A divider that matches under all three shows that the count follows `osc_en` and not the clock. Window lengths of 57, 58 and 690 ticks, together with a window that never closes, separate the accept band from the two discard edges. Starts placed right after a stop, exactly on the lockout exit edge and one cycle later locate the lockout boundary to the cycle. A second start inside an open window shows that the count is not reset. Random lengths between 150 and 250 ms then exercise repeated refinement.

// File: rtl/fcal_pkg.sv
package fcal_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_MEAS = 2'd1,
    WIN_LOCK = 2'd2
  } win_state_t;
endpackage

// File: rtl/fcal_window.sv
module fcal_window
  import fcal_pkg::*;
#(
  parameter int MIN_MS  = 58,
  parameter int MAX_MS  = 690,
  parameter int LOCK_MS = 500,
  parameter int MS_W    = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            stop_req,
  input  logic            ms_tick,
  input  logic            pwr_down,
  output logic            meas,
  output logic            clr,
  output logic            load,
  output logic            ok_q,
  output logic            drop_q,
  output logic [MS_W-1:0] ms_cnt
);
  localparam logic [MS_W-1:0] MIN_V  = MS_W'(MIN_MS);
  localparam logic [MS_W-1:0] MAX_V  = MS_W'(MAX_MS);
  localparam logic [MS_W-1:0] LOCK_V = MS_W'(LOCK_MS);

  win_state_t      st_q, st_nx;
  logic [MS_W-1:0] ms_q, ms_nx, ms_inc;
  logic            ok_nx, drop_nx;

  assign ms_inc = ms_q + MS_W'(ms_tick);

  always_comb begin
    st_nx   = st_q;
    ms_nx   = ms_q;
    ok_nx   = 1'b0;
    drop_nx = 1'b0;
    clr     = 1'b0;
    load    = 1'b0;
    case (st_q)
      WIN_IDLE: begin
        if (start_req) begin
          if (pwr_down) begin
            drop_nx = 1'b1;
          end else begin
            st_nx = WIN_MEAS;
            ms_nx = '0;
            clr   = 1'b1;
          end
        end
      end
      WIN_MEAS: begin
        if (pwr_down) begin
          drop_nx = 1'b1;
          st_nx   = WIN_LOCK;
          ms_nx   = '0;
        end else if (stop_req) begin
          if (ms_inc >= MIN_V && ms_inc <= MAX_V) begin
            ok_nx = 1'b1;
            load  = 1'b1;
          end else begin
            drop_nx = 1'b1;
          end
          st_nx = WIN_LOCK;
          ms_nx = '0;
        end else if (ms_inc > MAX_V) begin
          drop_nx = 1'b1;
          st_nx   = WIN_LOCK;
          ms_nx   = '0;
        end else begin
          ms_nx = ms_inc;
        end
      end
      WIN_LOCK: begin
        drop_nx = start_req;
        if (ms_inc >= LOCK_V) begin
          st_nx = WIN_IDLE;
          ms_nx = '0;
        end else begin
          ms_nx = ms_inc;
        end
      end
      default: st_nx = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WIN_IDLE;
      ms_q   <= '0;
      ok_q   <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      ms_q   <= ms_nx;
      ok_q   <= ok_nx;
      drop_q <= drop_nx;
    end
  end

  assign meas   = (st_q == WIN_MEAS);
  assign ms_cnt = ms_q;
endmodule

// File: rtl/fcal_meter.sv
module fcal_meter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             meas,
  input  logic             osc_en,
  output logic [CNT_W-1:0] cnt_fin
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (clr)                 cnt_nx = '0;
    else if (meas && osc_en) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign cnt_fin = cnt_q + CNT_W'(osc_en);
endmodule

// File: rtl/fcal_frame.sv
module fcal_frame #(
  parameter int DIV_W   = 16,
  parameter int SHIFT   = 4,
  parameter int DEF_DIV = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [DIV_W+SHIFT-1:0] cnt_fin,
  input  logic                   osc_en,
  input  logic                   pwr_down,
  output logic [DIV_W-1:0]       divider,
  output logic                   frame_tick
);
  localparam logic [DIV_W-1:0] DEF_V = DIV_W'(DEF_DIV);

  logic [DIV_W-1:0] div_q, div_nx, div_calc, fc_q, fc_nx;
  logic             hit;

  assign div_calc = DIV_W'(cnt_fin >> SHIFT);

  always_comb begin
    div_nx = div_q;
    if (load) div_nx = (div_calc == '0) ? DIV_W'(1) : div_calc;
  end

  assign hit = osc_en && !pwr_down && (fc_q >= div_q - 1'b1);

  always_comb begin
    fc_nx = fc_q;
    if (pwr_down)    fc_nx = '0;
    else if (hit)    fc_nx = '0;
    else if (osc_en) fc_nx = fc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= DEF_V;
      fc_q       <= '0;
      frame_tick <= 1'b0;
    end else begin
      div_q      <= div_nx;
      fc_q       <= fc_nx;
      frame_tick <= hit;
    end
  end

  assign divider = div_q;
endmodule

// File: rtl/fcal_ctrl.sv
module fcal_ctrl #(
  parameter int MIN_MS  = 58,
  parameter int MAX_MS  = 690,
  parameter int LOCK_MS = 500,
  parameter int DIV_W   = 16,
  parameter int SHIFT   = 4,
  parameter int DEF_DIV = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             ms_tick,
  input  logic             osc_en,
  input  logic             pwr_down,
  output logic [DIV_W-1:0] divider,
  output logic             frame_tick,
  output logic             cal_ok,
  output logic             cal_drop
);
  localparam int CNT_W  = DIV_W + SHIFT;
  localparam int MS_TOP = (MAX_MS + 1 > LOCK_MS) ? MAX_MS + 1 : LOCK_MS;
  localparam int MS_W   = $clog2(MS_TOP + 1);

  logic             meas, clr, load;
  logic [MS_W-1:0]  ms_cnt;
  logic [CNT_W-1:0] cnt_fin;

  fcal_window #(
    .MIN_MS(MIN_MS), .MAX_MS(MAX_MS), .LOCK_MS(LOCK_MS), .MS_W(MS_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .ms_tick(ms_tick), .pwr_down(pwr_down), .meas(meas), .clr(clr),
    .load(load), .ok_q(cal_ok), .drop_q(cal_drop), .ms_cnt(ms_cnt)
  );

  fcal_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .meas(meas), .osc_en(osc_en),
    .cnt_fin(cnt_fin)
  );

  fcal_frame #(.DIV_W(DIV_W), .SHIFT(SHIFT), .DEF_DIV(DEF_DIV)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(load), .cnt_fin(cnt_fin),
    .osc_en(osc_en), .pwr_down(pwr_down), .divider(divider),
    .frame_tick(frame_tick)
  );
endmodule

// File: rtl/fcal_ctrl_chk.sv
module fcal_ctrl_chk #(
  parameter int MAX_MS = 690,
  parameter int DIV_W  = 16,
  parameter int MS_W   = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             stop_req,
  input logic             ms_tick,
  input logic             pwr_down,
  input logic             cal_ok,
  input logic             cal_drop,
  input logic [DIV_W-1:0] divider,
  input logic             frame_tick,
  input logic             meas,
  input logic [MS_W-1:0]  ms_cnt
);
  localparam logic [MS_W-1:0] MAX_V = MS_W'(MAX_MS);

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_ok && cal_drop));

  p_div_only_on_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divider) |-> cal_ok);

  p_div_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    divider != '0);

  p_pd_start_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && pwr_down && !meas) |=> cal_drop);

  p_no_tick_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !frame_tick);

  p_timeout_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas && ms_cnt == MAX_V && ms_tick && !stop_req && !pwr_down)
      |=> (cal_drop && !meas));

  p_pd_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (meas && pwr_down) |=> (cal_drop && !meas));
endmodule

bind fcal_ctrl fcal_ctrl_chk #(.MAX_MS(MAX_MS), .DIV_W(DIV_W), .MS_W(MS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
  .ms_tick(ms_tick), .pwr_down(pwr_down), .cal_ok(cal_ok),
  .cal_drop(cal_drop), .divider(divider), .frame_tick(frame_tick),
  .meas(meas), .ms_cnt(ms_cnt)
);

// File: tb/fcal_ctrl_test.sv
module fcal_ctrl_test;
  localparam int MS_CYC = 8;
  localparam int LOCK   = 500;
  localparam int MAXW   = 690;

  logic        clk = 1'b0;
  logic        rst_n, start_req, stop_req, ms_tick, osc_en, pwr_down;
  logic [15:0] divider;
  logic        frame_tick, cal_ok, cal_drop;

  int n_chk = 0, n_fail = 0;
  int phase = 0, lk = 0, mode = 0, exp_div = 64;
  int last_osc = 0;
  bit cur_tick, cur_osc, got_ok, got_drop, done = 0;

  always #2 clk = ~clk;

  fcal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .ms_tick(ms_tick), .osc_en(osc_en), .pwr_down(pwr_down),
    .divider(divider), .frame_tick(frame_tick), .cal_ok(cal_ok),
    .cal_drop(cal_drop)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_d(int c);
    int d = c >> 4;
    return (d == 0) ? 1 : d;
  endfunction

  function automatic bit next_tick();
    return phase == MS_CYC - 1;
  endfunction

  task automatic step(bit st, bit sp);
    @(negedge clk);
    start_req = st;
    stop_req  = sp;
    ms_tick   = next_tick();
    case (mode)
      0:       osc_en = 1'b1;
      1:       osc_en = 1'($urandom % 2);
      default: osc_en = (phase % 3 == 0);
    endcase
    cur_tick = ms_tick;
    cur_osc  = osc_en;
    phase    = (phase + 1) % MS_CYC;
    @(posedge clk);
    #1;
    lk += int'(cur_tick);
  endtask

  // do_stop=0 runs to the timeout; xstart puts a second start inside the window
  task automatic cal(int len, int m, bit do_stop, bit xstart);
    int ms = 0, osc = 0, i = 0;
    bit flag = 0;
    mode = m;
    step(1'b1, 1'b0);
    forever begin
      bit t = next_tick();
      if (do_stop && t && ms + 1 == len) begin
        step(1'b0, 1'b1);
        osc += int'(cur_osc);
        break;
      end else if (!do_stop && t && ms + 1 == MAXW + 1) begin
        step(1'b0, 1'b0);
        break;
      end
      step(xstart && i == 5, 1'b0);
      ms  += int'(cur_tick);
      osc += int'(cur_osc);
      if (cal_ok || cal_drop) flag = 1;
      i++;
    end
    got_ok   = cal_ok;
    got_drop = cal_drop;
    last_osc = osc;
    lk       = 0;
    chk("R9 no status pulse inside window", flag, 0);
  endtask

  task automatic wait_lock();
    while (lk < LOCK) step(1'b0, 1'b0);
  endtask

  task automatic frame_gap(string req);
    int g = 0, w = 0;
    mode = 0;
    while (!frame_tick && w < 400) begin step(1'b0, 1'b0); w++; end
    do begin step(1'b0, 1'b0); g++; end while (!frame_tick && g < 400);
    chk(req, g, exp_div);
  endtask

  task automatic expect_accept(string req);
    chk({req, " cal_ok"}, got_ok, 1);
    chk({req, " cal_drop"}, got_drop, 0);
    exp_div = exp_d(last_osc);
    chk({req, " divider"}, divider, exp_div);
  endtask

  task automatic expect_drop(string req);
    chk({req, " cal_ok"}, got_ok, 0);
    chk({req, " cal_drop"}, got_drop, 1);
    chk({req, " divider kept"}, divider, exp_div);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_req = 0; stop_req = 0; ms_tick = 0;
    osc_en = 0; pwr_down = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 reset divider", divider, 64);
    chk("R1 reset cal_ok", cal_ok, 0);
    chk("R1 reset cal_drop", cal_drop, 0);
    frame_gap("R8 default frame period");

    cal(200, 0, 1, 0); expect_accept("R1 R3 first window");
    frame_gap("R8 calibrated frame period");
    step(1'b1, 1'b0);
    chk("R6 start right after stop", cal_drop, 1);
    chk("R6 divider unchanged", divider, exp_div);
    forever begin
      if (lk + int'(next_tick()) == LOCK) begin step(1'b1, 1'b0); break; end
      step(1'b0, 1'b0);
    end
    chk("R6 start on lockout exit edge", cal_drop, 1);
    cal(200, 2, 1, 0); expect_accept("R6 start one cycle after lockout");
    wait_lock();

    cal(57, 0, 1, 0); expect_drop("R4 57 ms window");
    wait_lock();
    cal(58, 1, 1, 0); expect_accept("R3 58 ms window");
    wait_lock();
    cal(690, 2, 1, 0); expect_accept("R5 690 ms window");
    wait_lock();
    cal(0, 0, 0, 0); expect_drop("R5 timeout without stop");
    wait_lock();

    pwr_down = 1'b1;
    step(1'b1, 1'b0);
    chk("R2 start in power-down drop", cal_drop, 1);
    chk("R2 divider kept", divider, exp_div);
    begin
      int ticks = 0;
      repeat (200) begin step(1'b0, 1'b0); ticks += int'(frame_tick); end
      chk("R8 no frame tick in power-down", ticks, 0);
    end
    pwr_down = 1'b0;

    step(1'b0, 1'b1);
    chk("R9 stop while idle ok", cal_ok, 0);
    chk("R9 stop while idle drop", cal_drop, 0);
    chk("R9 stop while idle divider", divider, exp_div);

    cal(200, 1, 1, 1); expect_accept("R9 second start inside window");
    wait_lock();

    mode = 0;
    step(1'b1, 1'b0);
    repeat (50) step(1'b0, 1'b0);
    pwr_down = 1'b1;
    step(1'b0, 1'b0);
    chk("R9 power-down aborts window", cal_drop, 1);
    chk("R9 divider kept after abort", divider, exp_div);
    pwr_down = 1'b0;
    lk = 0;
    wait_lock();

    for (int k = 0; k < 5; k++) begin
      cal(150 + int'($urandom % 101), int'($urandom % 3), 1, 0);
      expect_accept("R7 R3 repeated refinement");
      chk("R10 flags exclusive", got_ok && got_drop, 0);
      wait_lock();
    end
    frame_gap("R8 final frame period");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule